// File: doc/BRIEF.md
# Serial Programming Entry Controller

This block is the master side of a four-wire serial link (clock, data out, data in, target reset) that brings a target microcontroller into its serial programming mode. After a start request from the host it raises the target reset line for a fixed number of system clocks while the serial clock is held low. It then waits a configurable number of milliseconds, counted from the system clock through a divider. Finally it shifts out a four-byte enable frame, most significant bit first.

While the third byte goes out, the target should return the second byte it received. The block compares that returned byte with the expected synchronisation value. The frame is always completed, even when the comparison fails. If the returned byte matches, the block reports success. If it does not, the block pulses the target reset again and repeats the whole attempt, up to a configurable number of retries, and then reports failure. The host sees a busy flag, a success flag, a failure flag and the retry count.

Top module: `prog_entry_ctrl`

## Requirements
- R1: After reset, `tgt_reset`, `sck`, `mosi`, `busy`, `entered` and `failed` are 0 and `retries` is 0.
- R2: A start request raises `tgt_reset` for exactly RST_PULSE system clocks, and `sck` stays low for all of that time.
- R3: After `tgt_reset` falls, no rising edge of `sck` occurs for at least WAIT_MS × TICKS_PER_MS system clocks.
- R4: Each attempt sends the 32-bit frame {CMD_BYTE, SYNC_BYTE, 0x00, 0x00} on `mosi`, most significant bit first. The default is 0xAC, 0x53, 0x00, 0x00. Each `sck` high phase and low phase lasts SCK_HALF clocks, and `mosi` never changes while `sck` is high.
- R5: `miso` is captured at each rising edge of `sck`. The 8 bits captured during the third byte (frame bits 15..8) are compared with SYNC_BYTE.
- R6: Every attempt produces exactly 32 rising edges of `sck`, whether or not the echo matches.
- R7: On a match, `entered` goes to 1 and `busy` to 0, and `retries` holds the number of failed attempts before it. `entered` and `failed` are never 1 together.
- R8: On a mismatch while `retries` < MAX_RETRY, `retries` increments and a new reset pulse and frame follow. On a mismatch with `retries` = MAX_RETRY, `failed` goes to 1 after MAX_RETRY+1 frames in total.
- R9: Once `entered` or `failed` is set, `sck` and `tgt_reset` stay low until the next start.
- R10: `start` is ignored while `busy` is 1.
- R11: A start from the idle, entered or failed state clears both flags and `retries`, and sets `busy` one clock later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Host request to begin entry |
| miso | input | 1 | Serial data from target |
| sck | output | 1 | Serial clock to target |
| mosi | output | 1 | Serial data to target |
| tgt_reset | output | 1 | Target reset line, high during the pulse |
| busy | output | 1 | Entry sequence in progress |
| entered | output | 1 | Synchronisation confirmed |
| failed | output | 1 | Retry limit exhausted |
| retries | output | $clog2(MAX_RETRY+1) | Number of failed attempts so far |

## Verification
A target model answers each frame with a chosen echo, good or corrupted, and the bench probes several sequences. These are a first-try match, a match after some misses, a match on exactly the last allowed retry, and a miss on every attempt. A controller with an off-by-one in its limit check would fail one attempt early or retry one time too many, and the frame counts and reported retries catch either. A controller that stops a frame once the echo is known would leave fewer than 32 clock pulses in that attempt. A controller that measured the echo from the wrong byte slot would never report entry. A start request issued mid-sequence would, if honoured, add an extra reset pulse and frame, and the frame count exposes it.

// File: rtl/prog_entry_pkg.sv
package prog_entry_pkg;

   localparam int FRAME_BYTES = 4;
   localparam int FRAME_BITS  = FRAME_BYTES * 8;
   // byte slot (0 = first on the wire) whose returned value carries the echo
   localparam int ECHO_SLOT   = 2;
   localparam int ECHO_LSB    = (FRAME_BYTES - 1 - ECHO_SLOT) * 8;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_PULSE,
      ST_WAIT,
      ST_SEND,
      ST_ENTERED,
      ST_FAILED
   } pe_state_e;

   function automatic logic [FRAME_BITS-1:0] build_frame(input logic [7:0] cmd,
                                                         input logic [7:0] sync);
      return {cmd, sync, {(FRAME_BITS-16){1'b0}}};
   endfunction

endpackage

// File: rtl/pe_ms_timer.sv
module pe_ms_timer #(
   parameter int TICKS_PER_MS = 1000,
   parameter int WAIT_MS      = 20
) (
   input  logic clk,
   input  logic rst_n,
   input  logic go,
   output logic done
);
   localparam int MW = (WAIT_MS > 1) ? $clog2(WAIT_MS) : 1;
   localparam logic [MW-1:0] MS_LAST = MW'(WAIT_MS - 1);

   logic          run;
   logic          tick;
   logic [MW-1:0] ms_cnt;

   if (TICKS_PER_MS < 1) begin : g_bad_ticks
      $error("pe_ms_timer: TICKS_PER_MS must be at least 1");
   end
   if (WAIT_MS < 1) begin : g_bad_wait
      $error("pe_ms_timer: WAIT_MS must be at least 1");
   end

   if (TICKS_PER_MS > 1) begin : g_prescale
      localparam int PW = $clog2(TICKS_PER_MS);
      localparam logic [PW-1:0] PRE_LAST = PW'(TICKS_PER_MS - 1);
      logic [PW-1:0] pre_cnt;

      always_ff @(posedge clk) begin
         if (!rst_n || go) begin
            pre_cnt <= '0;
         end else if (run) begin
            pre_cnt <= (pre_cnt == PRE_LAST) ? '0 : pre_cnt + 1'b1;
         end
      end
      assign tick = run && (pre_cnt == PRE_LAST);
   end else begin : g_direct
      assign tick = run;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run    <= 1'b0;
         ms_cnt <= '0;
         done   <= 1'b0;
      end else begin
         done <= 1'b0;
         if (go) begin
            run    <= 1'b1;
            ms_cnt <= '0;
         end else if (tick) begin
            if (ms_cnt == MS_LAST) begin
               run    <= 1'b0;
               ms_cnt <= '0;
               done   <= 1'b1;
            end else begin
               ms_cnt <= ms_cnt + 1'b1;
            end
         end
      end
   end

   // done may only follow a cycle in which the timer was counting
   assert_done_after_run_R3: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(run));

endmodule

// File: rtl/pe_frame_shifter.sv
module pe_frame_shifter
   import prog_entry_pkg::*;
#(
   parameter int SCK_HALF = 4
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  go,
   input  logic [FRAME_BITS-1:0] frame_in,
   input  logic                  miso,
   output logic                  sck,
   output logic                  mosi,
   output logic [FRAME_BITS-1:0] rx_frame,
   output logic                  done,
   output logic                  active
);
   localparam int BW = $clog2(FRAME_BITS);
   localparam int HW = $clog2(SCK_HALF + 1);
   localparam logic [HW-1:0] HALF_LAST = HW'(SCK_HALF - 1);
   localparam logic [BW-1:0] BIT_LAST  = BW'(FRAME_BITS - 1);

   logic [FRAME_BITS-1:0] tx_q;
   logic [BW-1:0]         bit_idx;
   logic [HW-1:0]         half_cnt;

   if (SCK_HALF < 2) begin : g_bad_half
      $error("pe_frame_shifter: SCK_HALF must be at least 2");
   end

   assign mosi = tx_q[FRAME_BITS-1];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tx_q     <= '0;
         rx_frame <= '0;
         bit_idx  <= '0;
         half_cnt <= '0;
         sck      <= 1'b0;
         active   <= 1'b0;
         done     <= 1'b0;
      end else begin
         done <= 1'b0;
         if (go && !active) begin
            tx_q     <= frame_in;
            bit_idx  <= '0;
            half_cnt <= '0;
            sck      <= 1'b0;
            active   <= 1'b1;
         end else if (active) begin
            if (half_cnt != HALF_LAST) begin
               half_cnt <= half_cnt + 1'b1;
            end else begin
               half_cnt <= '0;
               if (!sck) begin
                  // rising edge: the target has held miso since the last fall
                  sck      <= 1'b1;
                  rx_frame <= {rx_frame[FRAME_BITS-2:0], miso};
               end else begin
                  sck <= 1'b0;
                  if (bit_idx == BIT_LAST) begin
                     active <= 1'b0;
                     done   <= 1'b1;
                  end else begin
                     bit_idx <= bit_idx + 1'b1;
                     tx_q    <= {tx_q[FRAME_BITS-2:0], 1'b0};
                  end
               end
            end
         end
      end
   end

   // data toward the target never moves during a high phase
   assert_mosi_steady_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
      sck |-> $stable(mosi));

   // the clock only runs inside a frame
   assert_sck_inside_frame_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sck) |-> active);

endmodule

// File: rtl/prog_entry_ctrl.sv
module prog_entry_ctrl
   import prog_entry_pkg::*;
#(
   parameter int          TICKS_PER_MS = 1000,
   parameter int          WAIT_MS      = 20,
   parameter int          RST_PULSE    = 4,
   parameter int          TGT_CYC      = 1,
   parameter int          SCK_HALF     = 4,
   parameter int          MAX_RETRY    = 8,
   parameter logic [7:0]  CMD_BYTE     = 8'hAC,
   parameter logic [7:0]  SYNC_BYTE    = 8'h53
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           start,
   input  logic                           miso,
   output logic                           sck,
   output logic                           mosi,
   output logic                           tgt_reset,
   output logic                           busy,
   output logic                           entered,
   output logic                           failed,
   output logic [$clog2(MAX_RETRY+1)-1:0] retries
);
   localparam int RW = $clog2(MAX_RETRY + 1);
   localparam int CW = (RST_PULSE > 1) ? $clog2(RST_PULSE) : 1;
   localparam logic [CW-1:0] PULSE_LAST = CW'(RST_PULSE - 1);
   localparam logic [RW-1:0] RETRY_MAX  = RW'(MAX_RETRY);
   localparam logic [FRAME_BITS-1:0] ENABLE_FRAME = build_frame(CMD_BYTE, SYNC_BYTE);

   if (SCK_HALF <= 2 * TGT_CYC) begin : g_bad_sck
      $error("prog_entry_ctrl: SCK period must exceed four target clock cycles");
   end
   if (RST_PULSE < 2 * TGT_CYC) begin : g_bad_pulse
      $error("prog_entry_ctrl: reset pulse shorter than two target clock cycles");
   end
   if (MAX_RETRY < 1) begin : g_bad_retry
      $error("prog_entry_ctrl: MAX_RETRY must be at least 1");
   end

   pe_state_e              state;
   logic [CW-1:0]          pulse_cnt;
   logic                   wait_go;
   logic                   wait_done;
   logic                   shift_go;
   logic                   frame_done;
   logic                   shift_active;
   logic [FRAME_BITS-1:0]  rx_frame;
   logic                   echo_ok;

   assign wait_go  = (state == ST_PULSE) && (pulse_cnt == PULSE_LAST);
   assign shift_go = (state == ST_WAIT) && wait_done;
   assign echo_ok  = (rx_frame[ECHO_LSB +: 8] == SYNC_BYTE);

   pe_ms_timer #(
      .TICKS_PER_MS (TICKS_PER_MS),
      .WAIT_MS      (WAIT_MS)
   ) u_wait (
      .clk   (clk),
      .rst_n (rst_n),
      .go    (wait_go),
      .done  (wait_done)
   );

   pe_frame_shifter #(
      .SCK_HALF (SCK_HALF)
   ) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .go       (shift_go),
      .frame_in (ENABLE_FRAME),
      .miso     (miso),
      .sck      (sck),
      .mosi     (mosi),
      .rx_frame (rx_frame),
      .done     (frame_done),
      .active   (shift_active)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         pulse_cnt <= '0;
         retries   <= '0;
      end else begin
         unique case (state)
            ST_IDLE, ST_ENTERED, ST_FAILED: begin
               if (start) begin
                  state     <= ST_PULSE;
                  pulse_cnt <= '0;
                  retries   <= '0;
               end
            end
            ST_PULSE: begin
               if (pulse_cnt == PULSE_LAST) begin
                  state     <= ST_WAIT;
                  pulse_cnt <= '0;
               end else begin
                  pulse_cnt <= pulse_cnt + 1'b1;
               end
            end
            ST_WAIT: begin
               if (wait_done) state <= ST_SEND;
            end
            ST_SEND: begin
               if (frame_done) begin
                  if (echo_ok) begin
                     state <= ST_ENTERED;
                  end else if (retries == RETRY_MAX) begin
                     state <= ST_FAILED;
                  end else begin
                     retries   <= retries + 1'b1;
                     pulse_cnt <= '0;
                     state     <= ST_PULSE;
                  end
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign tgt_reset = (state == ST_PULSE);
   assign busy      = (state == ST_PULSE) || (state == ST_WAIT) || (state == ST_SEND);
   assign entered   = (state == ST_ENTERED);
   assign failed    = (state == ST_FAILED);

   assert_sck_low_in_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
      tgt_reset |-> !sck);

   assert_flags_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !(entered && failed));

   assert_retry_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
      retries <= RETRY_MAX);

   assert_fail_at_limit_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(failed) |-> (retries == RETRY_MAX) && $past(frame_done));

   assert_entry_after_frame_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(entered) |-> $past(frame_done));

   assert_quiet_when_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !sck && !shift_active);

endmodule

// File: tb/prog_entry_ctrl_tb.sv
`timescale 1ns/1ps
module prog_entry_ctrl_tb;
   localparam int TPM = 10;
   localparam int WMS = 20;
   localparam int RP  = 3;
   localparam int SH  = 3;
   localparam int MR  = 3;
   localparam int RW  = $clog2(MR + 1);
   localparam logic [31:0] EXP_FRAME = 32'hAC53_0000;
   localparam logic [31:0] GOOD_RESP = 32'h00AC_5300;
   localparam logic [31:0] BAD_RESP  = 32'h00AC_3500;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic miso = 1'b0;
   logic sck, mosi, tgt_reset, busy, entered, failed;
   logic [RW-1:0] retries;

   always #2.5 clk = ~clk;

   prog_entry_ctrl #(
      .TICKS_PER_MS (TPM),
      .WAIT_MS      (WMS),
      .RST_PULSE    (RP),
      .TGT_CYC      (1),
      .SCK_HALF     (SH),
      .MAX_RETRY    (MR)
   ) u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .miso      (miso),
      .sck       (sck),
      .mosi      (mosi),
      .tgt_reset (tgt_reset),
      .busy      (busy),
      .entered   (entered),
      .failed    (failed),
      .retries   (retries)
   );

   int checks = 0;
   int fails  = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   typedef struct { bit fail; int retr; } outcome_t;
   bit       good_q[$];
   outcome_t exp_q[$];
   int       frames = 0;

   // target model and monitor, all on the falling system clock edge
   logic        p_sck = 0, p_rst = 0, p_fin = 0, p_mosi = 0;
   int          hi_run = 0, rst_run = 0, gap = 0, bitk = 32;
   bit          gap_on = 0, sck_in_rst = 0;
   logic [31:0] rxf = '0, resp = '0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (tgt_reset) begin
            rst_run++;
            if (sck) sck_in_rst = 1;
         end
         if (p_rst && !tgt_reset) begin
            chk(rst_run == RP, "R2", "reset pulse length", rst_run, RP);
            chk(!sck_in_rst, "R2", "sck low during pulse", sck_in_rst, 0);
            chk(bitk == 32, "R6", "rising edges in previous frame", bitk, 32);
            rst_run = 0; sck_in_rst = 0;
            gap_on = 1; gap = 0; bitk = 0;
            resp = (good_q.size() > 0 && good_q.pop_front()) ? GOOD_RESP : BAD_RESP;
            miso = resp[31];
         end else if (gap_on && !sck) begin
            gap++;
         end
         if (sck && !p_sck) begin
            if (gap_on) begin
               chk(gap >= TPM * WMS, "R3", "wait before first clock", gap, TPM * WMS);
               gap_on = 0;
            end
            rxf = {rxf[30:0], mosi};
            bitk++;
            if (bitk == 32) begin
               chk(rxf == EXP_FRAME, "R4", "enable frame", rxf, EXP_FRAME);
               frames++;
            end
         end
         if (sck) hi_run = p_sck ? hi_run + 1 : 1;
         if (sck && p_sck && (mosi != p_mosi))
            chk(0, "R4", "mosi moved while sck high", mosi, p_mosi);
         if (!sck && p_sck) begin
            chk(hi_run == SH, "R4", "sck high phase", hi_run, SH);
            if (bitk < 32) miso = resp[31 - bitk];
         end
         if ((entered || failed) && !p_fin) begin
            if (exp_q.size() == 0) begin
               chk(0, "R7", "unexpected completion", 1, 0);
            end else begin
               outcome_t e;
               e = exp_q.pop_front();
               chk(failed == e.fail, e.fail ? "R8" : "R7", "failed flag", failed, e.fail);
               chk(entered == !e.fail, "R7", "entered flag", entered, !e.fail);
               chk(retries == RW'(e.retr), e.fail ? "R8" : "R7", "retry count", retries, e.retr);
               chk(bitk == 32, "R6", "last frame complete", bitk, 32);
               chk(!busy, "R7", "busy cleared", busy, 0);
            end
         end
      end
      p_sck = sck; p_rst = tgt_reset; p_fin = entered || failed; p_mosi = mosi;
   end

   // driver: queues target answers and the expected outcome, then runs one session
   task automatic run_session(input int n_bad, input bit expect_fail, input bit poke);
      outcome_t o;
      bit quiet = 1;
      frames = 0;
      for (int i = 0; i < n_bad; i++) good_q.push_back(1'b0);
      if (!expect_fail) good_q.push_back(1'b1);
      o.fail = expect_fail;
      o.retr = expect_fail ? MR : n_bad;
      exp_q.push_back(o);
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
      chk(busy && !entered && !failed, "R11", "cleared and busy after start",
          {busy, entered, failed}, 3'b100);
      if (poke) begin
         repeat (50) @(negedge clk);
         start = 1'b1;
         @(negedge clk) start = 1'b0;
      end
      while (busy) @(negedge clk);
      repeat (3) @(negedge clk);
      chk(frames == (expect_fail ? MR + 1 : n_bad + 1), poke ? "R10" : "R8",
          "frames in session", frames, expect_fail ? MR + 1 : n_bad + 1);
      chk(exp_q.size() == 0, "R7", "outcome seen", exp_q.size(), 0);
      repeat (40) begin
         @(negedge clk);
         if (sck || tgt_reset || busy) quiet = 0;
      end
      chk(quiet, "R9", "lines held low after completion", quiet, 1);
      good_q.delete();
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk({tgt_reset, sck, mosi, busy, entered, failed} == 6'b0, "R1",
          "outputs after reset", {tgt_reset, sck, mosi, busy, entered, failed}, 0);
      chk(retries == 0, "R1", "retries after reset", retries, 0);
      run_session(0, 1'b0, 1'b0);   // first try matches (R5, R7)
      run_session(2, 1'b0, 1'b1);   // two misses, start poked mid-wait (R10)
      run_session(MR, 1'b0, 1'b0);  // match on the last allowed retry (R8)
      run_session(MR + 1, 1'b1, 1'b0); // every attempt misses (R8)
      run_session(1, 1'b0, 1'b0);   // restart from failed (R11)
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule